// File: doc/BRIEF.md
# UART RTS/CTS Flow Controller

This block sits next to a UART transmitter and receiver and handles hardware handshaking on the modem lines. On the transmit side it decides when the transmitter may begin each character. It checks the clear-to-send line only at a character boundary, and it issues a one-cycle start permit aligned to the bit clock. It can also drive request-to-send around a transmit burst. The line is raised one full bit period before the first start bit and dropped one bit period after the final stop bit.

On the receive side, request-to-send can instead show receive-buffer room. The line is held active while the receive occupancy is below a programmable watermark and released once the watermark is reached. The active level of request-to-send is programmable. The clear-to-send pin is active-low and passes through a two-flop synchroniser. Serialisation, buffering and baud generation stay with the UART; this block sees only a bit-time tick and a few status lines.

Top module: `uart_flow_ctrl`

## Requirements
- R1: While and right after reset, tx_start_ok is low and rts_pin sits at its inactive level (high when rts_active_high is 0, low when it is 1).
- R2: tx_start_ok is a single-cycle pulse. It is high only in the cycle after a cycle with bit_tick high, and exactly one pulse is issued for each character taken from tx_pending.
- R3: With cts_gate_en set, no permit is issued while the synchronised clear-to-send is deasserted (cts_n_in high). The character waits, and the permit follows at a bit tick no earlier than three cycles after cts_n_in goes low.
- R4: A change of cts_n_in while a character is being shifted does not affect that character. It completes and the burst continues or ends normally; only the next character start is held.
- R5: With cts_gate_en clear, cts_n_in has no effect on when permits are issued.
- R6: With tx_rts_en set and the transmit side idle, a pending character makes RTS go active at a bit tick. The permit then follows at the next bit tick, so RTS leads the start bit by exactly one bit period.
- R7: With tx_rts_en set, RTS stays active between back-to-back characters of a burst. It goes inactive at the first bit tick after tx_stop_done of the last character, which is one bit period when tx_stop_done coincides with a tick.
- R8: rts_active_high set makes RTS active-high; clear makes it active-low. The transmit lead and lag timing is the same under both polarities.
- R9: With rx_rts_en set and tx_rts_en clear, RTS is active while rx_count < rx_water and inactive while rx_count >= rx_water (a watermark of 0 keeps it inactive).
- R10: With both tx_rts_en and rx_rts_en clear, RTS stays inactive. When both are set, the transmit side controls RTS.
- R11: With tx_rts_en clear, the permit for a pending character comes at the first bit tick, with no lead time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cts_n_in | input | 1 | Clear-to-send pin, active-low, asynchronous |
| bit_tick | input | 1 | One-cycle pulse at each bit-time boundary |
| tx_pending | input | 1 | Transmit buffer holds at least one character |
| tx_busy | input | 1 | Transmit shift register is sending a character |
| tx_stop_done | input | 1 | Pulse when the last stop bit of a character ends |
| rx_count | input | CNT_W | Receive buffer occupancy |
| rx_water | input | CNT_W | Receive watermark |
| cts_gate_en | input | 1 | Gate character starts on clear-to-send |
| tx_rts_en | input | 1 | Drive RTS around transmit bursts |
| rx_rts_en | input | 1 | Drive RTS from receive occupancy |
| rts_active_high | input | 1 | RTS polarity: 1 active-high, 0 active-low |
| tx_start_ok | output | 1 | One-cycle start permit to the transmitter |
| rts_pin | output | 1 | Request-to-send pin |

## Verification
The assertions rely on the environment behaving like a well-formed transmitter. tx_busy rises only after a permit, tx_stop_done ends each character while the block is in its send phase, and the enable and polarity inputs are held steady while a burst is in flight. The stimulus keeps to this in three ways. The bench transmitter model starts shifting only on a permit and raises tx_stop_done on a bit tick after a fixed number of ticks. Configuration changes are made only once the transmit side has drained and its lag has expired. Clear-to-send is toggled freely, including in the middle of a character, because the block must tolerate that.

// File: rtl/uart_fc_pkg.sv
package uart_fc_pkg;

    typedef enum logic [1:0] {
        FC_IDLE  = 2'd0,
        FC_ARMED = 2'd1,
        FC_SEND  = 2'd2,
        FC_LAG   = 2'd3
    } fc_state_e;

    typedef struct packed {
        logic cts_gate;
        logic tx_rts;
        logic rx_rts;
        logic act_high;
    } fc_cfg_t;

    function automatic logic fc_pin_level(input logic active, input logic act_high);
        return act_high ? active : ~active;
    endfunction

endpackage

// File: rtl/uart_fc_sync.sv
module uart_fc_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic d_in,
    output logic d_out
);
    logic [STAGES-1:0] sr;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) sr[0] <= RST_VAL;
                    else     sr[0] <= d_in;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) sr[g] <= RST_VAL;
                    else     sr[g] <= sr[g-1];
                end
            end
        end
    endgenerate

    assign d_out = sr[STAGES-1];
endmodule

// File: rtl/uart_fc_tx_seq.sv
module uart_fc_tx_seq
    import uart_fc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic bit_tick,
    input  logic tx_pending,
    input  logic tx_busy,
    input  logic tx_stop_done,
    input  logic cts_ok,
    input  logic lead_en,
    output logic start_ok,
    output logic rts_req
);
    fc_state_e state_q, state_d;
    logic      permit_d;

    always_comb begin
        state_d  = state_q;
        permit_d = 1'b0;
        unique case (state_q)
            FC_IDLE: begin
                if (tx_pending && !tx_busy && bit_tick) begin
                    if (lead_en) begin
                        state_d = FC_ARMED;
                    end else if (cts_ok) begin
                        permit_d = 1'b1;
                        state_d  = FC_SEND;
                    end
                end
            end
            FC_ARMED: begin
                if (!tx_pending) begin
                    state_d = FC_LAG;
                end else if (bit_tick && cts_ok && !tx_busy) begin
                    permit_d = 1'b1;
                    state_d  = FC_SEND;
                end
            end
            FC_SEND: begin
                if (tx_stop_done) begin
                    state_d = tx_pending ? FC_ARMED : FC_LAG;
                end
            end
            FC_LAG: begin
                if (tx_pending)    state_d = FC_ARMED;
                else if (bit_tick) state_d = FC_IDLE;
            end
            default: state_d = FC_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= FC_IDLE;
            start_ok <= 1'b0;
        end else begin
            state_q  <= state_d;
            start_ok <= permit_d;
        end
    end

    assign rts_req = (state_q != FC_IDLE);
endmodule

// File: rtl/uart_fc_rx_mark.sv
module uart_fc_rx_mark #(
    parameter int CNT_W = 8
) (
    input  logic [CNT_W-1:0] rx_count,
    input  logic [CNT_W-1:0] rx_water,
    output logic             room_req
);
    assign room_req = (rx_count < rx_water);
endmodule

// File: rtl/uart_fc_rts_sel.sv
module uart_fc_rts_sel
    import uart_fc_pkg::*;
(
    input  fc_cfg_t cfg,
    input  logic    tx_req,
    input  logic    rx_req,
    output logic    rts_pin
);
    logic active;

    always_comb begin
        if (cfg.tx_rts)      active = tx_req;
        else if (cfg.rx_rts) active = rx_req;
        else                 active = 1'b0;
        rts_pin = fc_pin_level(active, cfg.act_high);
    end
endmodule

// File: rtl/uart_flow_ctrl.sv
module uart_flow_ctrl
    import uart_fc_pkg::*;
#(
    parameter int CNT_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cts_n_in,
    input  logic             bit_tick,
    input  logic             tx_pending,
    input  logic             tx_busy,
    input  logic             tx_stop_done,
    input  logic [CNT_W-1:0] rx_count,
    input  logic [CNT_W-1:0] rx_water,
    input  logic             cts_gate_en,
    input  logic             tx_rts_en,
    input  logic             rx_rts_en,
    input  logic             rts_active_high,
    output logic             tx_start_ok,
    output logic             rts_pin
);
    fc_cfg_t cfg;
    logic    cts_n_sync;
    logic    cts_ok;
    logic    tx_req;
    logic    rx_req;

    assign cfg.cts_gate = cts_gate_en;
    assign cfg.tx_rts   = tx_rts_en;
    assign cfg.rx_rts   = rx_rts_en;
    assign cfg.act_high = rts_active_high;

    uart_fc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_cts_sync (
        .clk   (clk),
        .rst   (rst),
        .d_in  (cts_n_in),
        .d_out (cts_n_sync)
    );

    assign cts_ok = !cfg.cts_gate || !cts_n_sync;

    uart_fc_tx_seq u_tx_seq (
        .clk          (clk),
        .rst          (rst),
        .bit_tick     (bit_tick),
        .tx_pending   (tx_pending),
        .tx_busy      (tx_busy),
        .tx_stop_done (tx_stop_done),
        .cts_ok       (cts_ok),
        .lead_en      (cfg.tx_rts),
        .start_ok     (tx_start_ok),
        .rts_req      (tx_req)
    );

    uart_fc_rx_mark #(.CNT_W(CNT_W)) u_rx_mark (
        .rx_count (rx_count),
        .rx_water (rx_water),
        .room_req (rx_req)
    );

    uart_fc_rts_sel u_rts_sel (
        .cfg     (cfg),
        .tx_req  (tx_req),
        .rx_req  (rx_req),
        .rts_pin (rts_pin)
    );
endmodule

// File: rtl/uart_flow_ctrl_chk.sv
module uart_flow_ctrl_chk #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             bit_tick,
    input logic             tx_busy,
    input logic             cts_n_sync,
    input logic [CNT_W-1:0] rx_count,
    input logic [CNT_W-1:0] rx_water,
    input logic             cts_gate_en,
    input logic             tx_rts_en,
    input logic             rx_rts_en,
    input logic             rts_active_high,
    input logic             tx_start_ok,
    input logic             rts_pin
);
    AST_PERMIT_ON_TICK: assert property (@(posedge clk) disable iff (rst)
        tx_start_ok |-> $past(bit_tick)); // R2

    AST_PERMIT_SINGLE: assert property (@(posedge clk) disable iff (rst)
        tx_start_ok |=> !tx_start_ok); // R2

    AST_PERMIT_NOT_BUSY: assert property (@(posedge clk) disable iff (rst)
        tx_start_ok |-> !$past(tx_busy)); // R4

    AST_PERMIT_NEEDS_CTS: assert property (@(posedge clk) disable iff (rst)
        (tx_start_ok && cts_gate_en) |-> !$past(cts_n_sync)); // R3

    AST_LEAD_RTS_ACTIVE: assert property (@(posedge clk) disable iff (rst)
        (tx_start_ok && tx_rts_en) |-> $past(rts_pin == rts_active_high)); // R6

    AST_RX_FULL_RELEASE: assert property (@(posedge clk) disable iff (rst)
        (rx_rts_en && !tx_rts_en && (rx_count >= rx_water)) |-> (rts_pin != rts_active_high)); // R9

    AST_RTS_UNUSED_IDLE: assert property (@(posedge clk) disable iff (rst)
        (!rx_rts_en && !tx_rts_en) |-> (rts_pin != rts_active_high)); // R10
endmodule

bind uart_flow_ctrl uart_flow_ctrl_chk #(.CNT_W(CNT_W)) u_chk (
    .clk             (clk),
    .rst             (rst),
    .bit_tick        (bit_tick),
    .tx_busy         (tx_busy),
    .cts_n_sync      (cts_n_sync),
    .rx_count        (rx_count),
    .rx_water        (rx_water),
    .cts_gate_en     (cts_gate_en),
    .tx_rts_en       (tx_rts_en),
    .rx_rts_en       (rx_rts_en),
    .rts_active_high (rts_active_high),
    .tx_start_ok     (tx_start_ok),
    .rts_pin         (rts_pin)
);

// File: tb/uart_flow_ctrl_tb.sv
`timescale 1ns/1ps
module uart_flow_ctrl_tb;
    localparam int CNT_W      = 8;
    localparam int TICK_DIV   = 8;
    localparam int CHAR_TICKS = 10;
    localparam int K_PERMIT   = 0;
    localparam int K_FALL     = 1;

    typedef struct {
        int    kind;
        int    val;
        string req;
    } exp_t;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             cts_n_in = 1'b1;
    logic             bit_tick = 1'b0;
    logic             tx_pending = 1'b0;
    logic             tx_busy = 1'b0;
    logic             tx_stop_done = 1'b0;
    logic [CNT_W-1:0] rx_count = '0;
    logic [CNT_W-1:0] rx_water = '0;
    logic             cts_gate_en = 1'b0;
    logic             tx_rts_en = 1'b0;
    logic             rx_rts_en = 1'b0;
    logic             rts_active_high = 1'b0;
    logic             tx_start_ok;
    logic             rts_pin;

    uart_flow_ctrl #(.CNT_W(CNT_W), .SYNC_STAGES(2)) u_dut (
        .clk             (clk),
        .rst             (rst),
        .cts_n_in        (cts_n_in),
        .bit_tick        (bit_tick),
        .tx_pending      (tx_pending),
        .tx_busy         (tx_busy),
        .tx_stop_done    (tx_stop_done),
        .rx_count        (rx_count),
        .rx_water        (rx_water),
        .cts_gate_en     (cts_gate_en),
        .tx_rts_en       (tx_rts_en),
        .rx_rts_en       (rx_rts_en),
        .rts_active_high (rts_active_high),
        .tx_start_ok     (tx_start_ok),
        .rts_pin         (rts_pin)
    );

    always #10 clk = ~clk;

    int   n_chk = 0;
    int   n_err = 0;
    exp_t sb_q[$];

    int   cyc = 0;
    int   tick_cnt = 0;
    int   pend_cnt = 0;
    int   ticks_left = 0;
    int   chars_done = 0;
    int   perm_total = 0;
    int   perm_cyc = 0;
    int   rts_on_cnt = 0;
    int   lag_cnt = 0;
    logic prev_act = 1'b0;
    logic prev_perm = 1'b0;
    logic done = 1'b0;

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // Monitor, then transmitter model and bit tick generator
    always @(negedge clk) begin
        logic act;
        exp_t e;
        cyc++;
        if (!rst) begin
            act = (rts_pin === rts_active_high);
            if (tx_start_ok) begin
                perm_total++;
                perm_cyc = cyc;
                if (prev_perm) chk("R2 permit pulse width", 2, 1);
                if (sb_q.size() == 0) begin
                    chk("R2 unexpected permit", 1, 0);
                end else begin
                    e = sb_q.pop_front();
                    chk({e.req, " event kind"}, K_PERMIT, e.kind);
                    if (e.kind == K_PERMIT && e.val >= 0)
                        chk({e.req, " RTS lead cycles"}, rts_on_cnt, e.val);
                end
            end
            if (prev_act && !act && tx_rts_en) begin
                if (sb_q.size() == 0) begin
                    chk("R7 unexpected RTS release", 1, 0);
                end else begin
                    e = sb_q.pop_front();
                    chk({e.req, " event kind"}, K_FALL, e.kind);
                    if (e.kind == K_FALL && e.val >= 0)
                        chk({e.req, " RTS lag cycles"}, lag_cnt, e.val);
                end
            end
            rts_on_cnt = act ? rts_on_cnt + 1 : 0;
            lag_cnt++;
            prev_act  = act;
            prev_perm = tx_start_ok;
        end

        tick_cnt     = (tick_cnt + 1) % TICK_DIV;
        bit_tick     = (tick_cnt == 0);
        tx_stop_done = 1'b0;
        if (!rst && tx_start_ok) begin
            pend_cnt--;
            tx_busy    = 1'b1;
            ticks_left = CHAR_TICKS;
        end else if (tx_busy && bit_tick) begin
            ticks_left--;
            if (ticks_left == 0) begin
                tx_busy      = 1'b0;
                tx_stop_done = 1'b1;
                chars_done++;
                lag_cnt = 0;
            end
        end
        tx_pending = (pend_cnt > 0);
    end

    task automatic settle();
        @(negedge clk);
        #1;
    endtask

    task automatic wait_drain();
        while (pend_cnt != 0 || tx_busy) @(negedge clk);
        repeat (3 * TICK_DIV) @(negedge clk);
    endtask

    task automatic send_burst(input int n, input int lead, input string req);
        exp_t e;
        e.kind = K_PERMIT; e.val = lead; e.req = req;
        sb_q.push_back(e);
        for (int i = 1; i < n; i++) begin
            e.kind = K_PERMIT; e.val = -1; e.req = "R7";
            sb_q.push_back(e);
        end
        if (tx_rts_en) begin
            e.kind = K_FALL; e.val = TICK_DIV; e.req = (req == "R8") ? "R8" : "R7";
            sb_q.push_back(e);
        end
        settle();
        pend_cnt += n;
        wait_drain();
    endtask

    task automatic push_exp(input int kind, input int val, input string req);
        exp_t e;
        e.kind = kind; e.val = val; e.req = req;
        sb_q.push_back(e);
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            finish_run();
        end
    end

    initial begin
        int p0;
        int t0;
        int c0;
        repeat (3) @(negedge clk);
        chk("R1 rts_pin in reset", rts_pin, 1);
        chk("R1 tx_start_ok in reset", tx_start_ok, 0);
        settle();
        rst = 1'b0;
        repeat (2) @(negedge clk);
        chk("R1 rts_pin after reset", rts_pin, 1);
        chk("R1 tx_start_ok after reset", tx_start_ok, 0);

        // R11: no RTS lead, permit at first tick
        send_burst(1, 0, "R11");
        chk("R11 RTS stays inactive", rts_pin, 1);

        // R6/R7: transmit RTS, single and burst
        settle();
        tx_rts_en = 1'b1;
        send_burst(1, TICK_DIV, "R6");
        send_burst(3, TICK_DIV, "R6");
        chk("R7 RTS idle after burst", rts_pin, 1);

        // R3: CTS gating holds the start
        settle();
        cts_gate_en = 1'b1;
        cts_n_in    = 1'b1;
        push_exp(K_PERMIT, -1, "R3");
        push_exp(K_FALL, TICK_DIV, "R7");
        p0 = perm_total;
        settle();
        pend_cnt += 1;
        repeat (6 * TICK_DIV) @(negedge clk);
        chk("R3 no permit while CTS deasserted", perm_total, p0);
        chk("R6 RTS active while waiting", rts_pin, 0);
        settle();
        cts_n_in = 1'b0;
        t0 = cyc;
        while (perm_total == p0) @(negedge clk);
        chk("R3 synchroniser delay respected", (perm_cyc - t0) >= 3, 1);
        wait_drain();
        chk("R3 one permit after CTS", perm_total, p0 + 1);

        // R4: CTS drops mid-character
        push_exp(K_PERMIT, -1, "R4");
        push_exp(K_PERMIT, -1, "R4");
        push_exp(K_FALL, TICK_DIV, "R4");
        p0 = perm_total;
        c0 = chars_done;
        settle();
        pend_cnt += 2;
        while (!tx_busy) @(negedge clk);
        settle();
        cts_n_in = 1'b1;
        while (tx_busy) @(negedge clk);
        repeat (5 * TICK_DIV) @(negedge clk);
        chk("R4 character in flight completed", chars_done, c0 + 1);
        chk("R4 next start held", perm_total, p0 + 1);
        chk("R4 RTS held between characters", rts_pin, 0);
        settle();
        cts_n_in = 1'b0;
        wait_drain();
        chk("R4 second character sent", chars_done, c0 + 2);

        // R5: gating off ignores CTS
        settle();
        cts_gate_en = 1'b0;
        cts_n_in    = 1'b1;
        tx_rts_en   = 1'b0;
        p0 = perm_total;
        send_burst(1, 0, "R5");
        chk("R5 permit despite CTS high", perm_total, p0 + 1);
        settle();
        cts_n_in = 1'b0;

        // R8: active-high polarity
        settle();
        rts_active_high = 1'b1;
        tx_rts_en       = 1'b1;
        settle();
        chk("R8 idle level active-high", rts_pin, 0);
        send_burst(1, TICK_DIV, "R8");
        chk("R8 idle after burst", rts_pin, 0);

        // R9: receive watermark, active-low
        settle();
        tx_rts_en       = 1'b0;
        rx_rts_en       = 1'b1;
        rts_active_high = 1'b0;
        rx_water        = 8'd4;
        rx_count        = 8'd3;
        settle();
        chk("R9 below mark asserts", rts_pin, 0);
        rx_count = 8'd4;
        settle();
        chk("R9 at mark releases", rts_pin, 1);
        rx_count = 8'd9;
        settle();
        chk("R9 above mark releases", rts_pin, 1);
        rx_count = 8'd0;
        settle();
        chk("R9 empty asserts", rts_pin, 0);
        rx_water = 8'd0;
        settle();
        chk("R9 zero watermark releases", rts_pin, 1);
        rx_water        = 8'd4;
        rx_count        = 8'd2;
        rts_active_high = 1'b1;
        settle();
        chk("R9 active-high below mark", rts_pin, 1);

        // R10: both off, and transmit priority
        rx_rts_en = 1'b0;
        settle();
        chk("R10 both disabled inactive", rts_pin, 0);
        tx_rts_en = 1'b1;
        rx_rts_en = 1'b1;
        settle();
        chk("R10 transmit side has priority", rts_pin, 0);
        tx_rts_en = 1'b0;
        rx_rts_en = 1'b0;
        repeat (4) @(negedge clk);

        chk("R2 all expected events seen", sb_q.size(), 0);
        done = 1'b1;
        finish_run();
    end
endmodule